// File: doc/BRIEF.md
# Systolic Decimal Pi Engine

The engine computes pi to a fixed number of decimal digits. It uses a linear chain of BCD digit cells, one cell per digit. A start pulse begins the run. The engine then sums the two alternating power series whose total is pi/4: the series for arctan(1/2) followed by the series for arctan(1/3). The accumulated sum is finally multiplied by four by doubling it twice.

Each cell holds one decimal digit of three working registers:

- a power register, holding (1/x)^k;
- a term register, holding (1/x)^k / k;
- a sum register, holding the running total.

Long division by a small integer passes a remainder down the chain, starting at the most significant cell. Addition, subtraction and doubling pass a carry or borrow up the chain, starting at the least significant cell. Each of these passes completes within one clock cycle.

A sequencer steps through the terms. Each term takes three passes:

1. The power register is divided by k to form the term.
2. The term is added to or subtracted from the sum; the sign alternates on every term.
3. The power register is divided by x squared.

A series stops when the power register has become zero. The chain carries guard digits below the visible precision, and these cannot be read. When `done` is high, the digits are read through an address port. Address 0 holds the units digit.

Top module: `pi_engine`

## Requirements
- R1: After reset `done` is 0 and every readable digit is 0. This holds until the first `start` pulse.
- R2: A `start` pulse runs the computation, after which `done` rises. Address a (0 ≤ a < NDIG) then returns digit a of pi truncated to NDIG digits: address 0 returns 3, and addresses 1 upward return the fraction digits 1,4,1,5,9,…
- R3: Any address at or above NDIG returns 0. This includes the GUARD hidden guard digits.
- R4: Once `done` is high, it stays high and every digit stays unchanged until the next `start` pulse.
- R5: A `start` pulse arriving while a run is in progress is ignored. The run ends in the same number of cycles and with the same digits.
- R6: A `start` pulse while `done` is high restarts the engine. `done` is 0 in the following cycle, and the new run reproduces the same digits in the same number of cycles.
- R7: Every digit presented on `rd_digit` is a valid BCD value, from 0 to 9.
- R8: Every division pass leaves a final remainder smaller than its divisor. No addition or doubling pass carries out of the units cell.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Pulse that begins or restarts a computation |
| rd_addr | input | ADDR_W | Digit index, 0 = units digit |
| done | output | 1 | High when the result is complete |
| rd_digit | output | 4 | BCD digit at `rd_addr` (combinational) |

## Verification
The bound checker watches several properties on every cycle:

- the zero value of out-of-range addresses;
- that each digit is valid BCD;
- that `done` and the read data hold until the next start;
- that `done` falls after a restart pulse;
- that the engine is never busy and done at the same time;
- the arithmetic invariants inside the chain (remainder below divisor, no carry out of the top cell).

Only the bench scenarios can show the numerical result, because it depends on whole runs of both series: that the visible digits match pi exactly despite the truncation in every pass. Likewise, only the bench can show that a mid-run start leaves both the latency and the result unchanged.

// File: rtl/pi_pkg.sv
package pi_pkg;

    typedef logic [3:0] bcd_t;

    // Datapath operation selected by the sequencer for the current cycle
    typedef enum logic [2:0] {
        OP_IDLE,
        OP_CLR,
        OP_LOAD,
        OP_TERM,
        OP_ACC,
        OP_POW,
        OP_DBL
    } op_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_CLR,
        ST_LOAD,
        ST_TERM,
        ST_ACC,
        ST_POW,
        ST_DBL1,
        ST_DBL2,
        ST_DONE
    } st_e;

endpackage

// File: rtl/pi_div_cell.sv
// One digit stage of a long division by a small integer.
// Takes the remainder from the more significant neighbour and
// emits a quotient digit and a remainder for the next one down.
module pi_div_cell
    import pi_pkg::*;
#(
    parameter int KW = 7
) (
    input  logic [KW-1:0] rem_i,
    input  bcd_t          dig_i,
    input  logic [KW-1:0] dvs_i,
    output bcd_t          quo_o,
    output logic [KW-1:0] rem_o
);

    localparam int NW = KW + 4;

    logic [NW-1:0] num;
    logic [NW-1:0] dvs_ext;

    always_comb begin
        num     = ({4'b0000, rem_i} << 3) + ({4'b0000, rem_i} << 1)
                + {{KW{1'b0}}, dig_i};
        dvs_ext = {4'b0000, dvs_i};
        quo_o   = 4'(num / dvs_ext);
        rem_o   = KW'(num % dvs_ext);
    end

endmodule

// File: rtl/pi_add_cell.sv
// One digit stage of a decimal add or subtract.
// cy_i / cy_o carry a carry when adding and a borrow when subtracting.
module pi_add_cell
    import pi_pkg::*;
(
    input  bcd_t a_i,
    input  bcd_t b_i,
    input  logic sub_i,
    input  logic cy_i,
    output bcd_t d_o,
    output logic cy_o
);

    logic [4:0] rhs;
    logic [4:0] tot;

    always_comb begin
        rhs = {1'b0, b_i} + {4'b0000, cy_i};
        if (sub_i) begin
            if ({1'b0, a_i} < rhs) begin
                tot  = {1'b0, a_i} + 5'd10 - rhs;
                cy_o = 1'b1;
            end else begin
                tot  = {1'b0, a_i} - rhs;
                cy_o = 1'b0;
            end
        end else begin
            tot = {1'b0, a_i} + rhs;
            if (tot >= 5'd10) begin
                tot  = tot - 5'd10;
                cy_o = 1'b1;
            end else begin
                cy_o = 1'b0;
            end
        end
        d_o = 4'(tot);
    end

endmodule

// File: rtl/pi_seq.sv
// Term sequencer: walks both arctan series and the final doubling.
module pi_seq
    import pi_pkg::*;
#(
    parameter int KW    = 7,
    parameter int ARG_A = 2,
    parameter int ARG_B = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          pzero_i,
    output op_e           op_o,
    output logic [KW-1:0] dvs_o,
    output logic          neg_o,
    output logic          busy_o,
    output logic          done_o
);

    localparam logic [KW-1:0] XA  = KW'(ARG_A);
    localparam logic [KW-1:0] XB  = KW'(ARG_B);
    localparam logic [KW-1:0] XA2 = KW'(ARG_A * ARG_A);
    localparam logic [KW-1:0] XB2 = KW'(ARG_B * ARG_B);

    typedef struct packed {
        st_e           st;
        logic [KW-1:0] k;
        logic          second;
        logic          neg;
    } seq_t;

    seq_t seq_q, seq_d;
    op_e  op_d;
    logic [KW-1:0] dvs_d;

    always_comb begin
        seq_d = seq_q;
        op_d  = OP_IDLE;
        dvs_d = '0;
        case (seq_q.st)
            ST_IDLE, ST_DONE: begin
                if (start_i) seq_d.st = ST_CLR;
            end
            ST_CLR: begin
                op_d         = OP_CLR;
                seq_d.st     = ST_LOAD;
                seq_d.second = 1'b0;
                seq_d.k      = KW'(1);
                seq_d.neg    = 1'b0;
            end
            ST_LOAD: begin
                op_d     = OP_LOAD;
                dvs_d    = seq_q.second ? XB : XA;
                seq_d.st = ST_TERM;
            end
            ST_TERM: begin
                if (pzero_i) begin
                    if (!seq_q.second) begin
                        seq_d.second = 1'b1;
                        seq_d.k      = KW'(1);
                        seq_d.neg    = 1'b0;
                        seq_d.st     = ST_LOAD;
                    end else begin
                        seq_d.st = ST_DBL1;
                    end
                end else begin
                    op_d     = OP_TERM;
                    dvs_d    = seq_q.k;
                    seq_d.st = ST_ACC;
                end
            end
            ST_ACC: begin
                op_d     = OP_ACC;
                seq_d.st = ST_POW;
            end
            ST_POW: begin
                op_d      = OP_POW;
                dvs_d     = seq_q.second ? XB2 : XA2;
                seq_d.k   = seq_q.k + KW'(2);
                seq_d.neg = !seq_q.neg;
                seq_d.st  = ST_TERM;
            end
            ST_DBL1: begin
                op_d     = OP_DBL;
                seq_d.st = ST_DBL2;
            end
            ST_DBL2: begin
                op_d     = OP_DBL;
                seq_d.st = ST_DONE;
            end
            default: seq_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q <= '{st: ST_IDLE, k: '0, second: 1'b0, neg: 1'b0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign op_o   = op_d;
    assign dvs_o  = dvs_d;
    assign neg_o  = seq_q.neg;
    assign done_o = (seq_q.st == ST_DONE);
    assign busy_o = (seq_q.st != ST_DONE) && (seq_q.st != ST_IDLE);

endmodule

// File: rtl/pi_engine.sv
// Top: digit chain datapath plus sequencer.
module pi_engine
    import pi_pkg::*;
#(
    parameter int NDIG   = 20,
    parameter int GUARD  = 2,
    parameter int ADDR_W = 5,
    parameter int ARG_A  = 2,
    parameter int ARG_B  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              done,
    output logic [3:0]        rd_digit
);

    localparam int W  = NDIG + GUARD;
    localparam int KW = $clog2(4 * W + 8);

    typedef struct packed {
        logic [W-1:0][3:0] pw;
        logic [W-1:0][3:0] tm;
        logic [W-1:0][3:0] sm;
    } dp_t;

    dp_t dp_q, dp_d;

    op_e           op;
    logic [KW-1:0] dvs;
    logic          neg;
    logic          busy;
    logic          pzero;

    logic [W-1:0][3:0]  div_in;
    logic [W-1:0][3:0]  div_out;
    logic [W-1:0][3:0]  as_b;
    logic [W-1:0][3:0]  as_out;
    logic [W-1:0][KW-1:0] rem_in;
    logic [KW-1:0]      rem_tail;
    logic [W-1:0]       cy_in;
    logic               carry_top;
    logic               as_sub;

    assign pzero  = (dp_q.pw == '0);
    assign as_sub = (op == OP_ACC) && neg;

    pi_seq #(
        .KW    (KW),
        .ARG_A (ARG_A),
        .ARG_B (ARG_B)
    ) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start),
        .pzero_i (pzero),
        .op_o    (op),
        .dvs_o   (dvs),
        .neg_o   (neg),
        .busy_o  (busy),
        .done_o  (done)
    );

    // Cell 0 is the units digit, cell W-1 the least significant guard digit.
    for (genvar g = 0; g < W; g++) begin : g_cell
        logic [KW-1:0] rem_out;
        logic          cy_out;

        assign div_in[g] = (op == OP_LOAD) ? ((g == 0) ? 4'd1 : 4'd0) : dp_q.pw[g];
        assign as_b[g]   = (op == OP_DBL) ? dp_q.sm[g] : dp_q.tm[g];

        pi_div_cell #(.KW(KW)) u_div (
            .rem_i (rem_in[g]),
            .dig_i (div_in[g]),
            .dvs_i (dvs),
            .quo_o (div_out[g]),
            .rem_o (rem_out)
        );

        pi_add_cell u_add (
            .a_i   (dp_q.sm[g]),
            .b_i   (as_b[g]),
            .sub_i (as_sub),
            .cy_i  (cy_in[g]),
            .d_o   (as_out[g]),
            .cy_o  (cy_out)
        );

        if (g == 0) begin : g_top
            assign rem_in[g] = '0;
            assign carry_top = cy_out;
        end else begin : g_mid
            assign rem_in[g]  = g_cell[g-1].rem_out;
            assign cy_in[g-1] = cy_out;
        end

        if (g == W - 1) begin : g_bot
            assign rem_tail = rem_out;
            assign cy_in[g] = 1'b0;
        end
    end

    always_comb begin
        dp_d = dp_q;
        case (op)
            OP_CLR:          dp_d.sm = '0;
            OP_LOAD, OP_POW: dp_d.pw = div_out;
            OP_TERM:         dp_d.tm = div_out;
            OP_ACC, OP_DBL:  dp_d.sm = as_out;
            default:         dp_d = dp_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dp_q <= '0;
        end else begin
            dp_q <= dp_d;
        end
    end

    // Read port: visible digits only, guard digits read as zero.
    always_comb begin
        rd_digit = 4'd0;
        for (int i = 0; i < NDIG; i++) begin
            if (rd_addr == ADDR_W'(i)) rd_digit = dp_q.sm[i];
        end
    end

endmodule

// File: rtl/pi_engine_chk.sv
module pi_engine_chk
    import pi_pkg::*;
#(
    parameter int NDIG   = 20,
    parameter int ADDR_W = 5,
    parameter int KW     = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              done,
    input logic              busy,
    input logic [ADDR_W-1:0] rd_addr,
    input logic [3:0]        rd_digit,
    input op_e               op,
    input logic [KW-1:0]     dvs,
    input logic [KW-1:0]     rem_tail,
    input logic              carry_top
);

    logic started_q;

    always_ff @(posedge clk) begin
        if (!rst_n) started_q <= 1'b0;
        else if (start) started_q <= 1'b1;
    end

    // R1
    p_idle_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !started_q |-> (rd_digit == 4'd0 && !done));

    // R2
    p_done_after_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> started_q);

    // R3
    p_guard_hidden_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr >= ADDR_W'(NDIG)) |-> (rd_digit == 4'd0));

    // R4
    p_done_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> done);

    // R4
    p_digit_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> (!$stable(rd_addr) || $stable(rd_digit)));

    // R5
    p_busy_not_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));

    // R6
    p_restart_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && start) |=> !done);

    // R7
    p_bcd_digit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_digit <= 4'd9);

    // R8
    p_rem_below_divisor_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_LOAD || op == OP_TERM || op == OP_POW) |-> (rem_tail < dvs));

    // R8
    p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_ACC || op == OP_DBL) |-> !carry_top);

endmodule

bind pi_engine pi_engine_chk #(
    .NDIG   (NDIG),
    .ADDR_W (ADDR_W),
    .KW     (KW)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .done      (done),
    .busy      (busy),
    .rd_addr   (rd_addr),
    .rd_digit  (rd_digit),
    .op        (op),
    .dvs       (dvs),
    .rem_tail  (rem_tail),
    .carry_top (carry_top)
);

// File: tb/pi_engine_bench.sv
module pi_engine_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NDIG       = 20;
    localparam int ADDR_W     = 5;
    localparam int NVEC       = 24;
    localparam int RUN_LIMIT  = 5000;

    // Vector table: read address and the digit expected there once done.
    // Addresses 0..19 hold pi = 3.1415926535897932384 (R2); 20, 21 are the
    // guard positions and 25, 31 lie beyond the chain, all expected 0 (R3).
    localparam int VADDR [NVEC] = '{0, 1, 2, 3, 4, 5, 6, 7, 8, 9,
                                    10, 11, 12, 13, 14, 15, 16, 17, 18, 19,
                                    20, 21, 25, 31};
    localparam int VEXP  [NVEC] = '{3, 1, 4, 1, 5, 9, 2, 6, 5, 3,
                                    5, 8, 9, 7, 9, 3, 2, 3, 8, 4,
                                    0, 0, 0, 0};

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [ADDR_W-1:0] rd_addr = '0;
    logic              done;
    logic [3:0]        rd_digit;

    int n_chk  = 0;
    int n_fail = 0;

    pi_engine u_pi_engine (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .rd_addr  (rd_addr),
        .done     (done),
        .rd_digit (rd_digit)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic walk_table(input string tag);
        for (int i = 0; i < NVEC; i++) begin
            rd_addr = ADDR_W'(VADDR[i]);
            #1;
            check((VADDR[i] < NDIG) ? {tag, " R2 digit"} : {tag, " R3 hidden"},
                  int'(rd_digit), VEXP[i]);
        end
    endtask

    // Pulse start, optionally pulse it again at cycle inject_at, count to done.
    task automatic run(input int inject_at, input bit chk_drop, output int cyc);
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        cyc   = 1;
        start = (cyc == inject_at);
        if (chk_drop) check("R6 done drops after restart", int'(done), 0);
        while (!done && cyc < RUN_LIMIT) begin
            @(negedge clk);
            cyc++;
            start = (cyc == inject_at);
        end
        start = 1'b0;
        check("R2 run completes", int'(done), 1);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        int cyc1;
        int cyc2;
        int cyc3;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state, idle without start
        check("R1 done after reset", int'(done), 0);
        for (int a = 0; a < NDIG; a += 5) begin
            rd_addr = ADDR_W'(a);
            #1;
            check("R1 digit zero after reset", int'(rd_digit), 0);
        end
        repeat (10) @(negedge clk);
        check("R1 idle stays not done", int'(done), 0);

        // R2 / R3: first computation, then the vector table
        run(0, 1'b0, cyc1);
        walk_table("run1");

        // R7: every address reads as BCD
        for (int a = 0; a < (1 << ADDR_W); a++) begin
            rd_addr = ADDR_W'(a);
            #1;
            check("R7 bcd range", int'(rd_digit <= 4'd9), 1);
        end

        // R4: result holds without start
        repeat (20) @(negedge clk);
        check("R4 done holds", int'(done), 1);
        rd_addr = ADDR_W'(7);
        #1;
        check("R4 digit holds", int'(rd_digit), 6);

        // R6: restart from done
        run(0, 1'b1, cyc2);
        check("R6 same latency on restart", cyc2, cyc1);
        walk_table("run2");

        // R5: extra start during a run is ignored
        run(25, 1'b0, cyc3);
        check("R5 same latency with mid-run start", cyc3, cyc1);
        walk_table("run3");

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule